// File: doc/BRIEF.md
# SPI EEPROM Word Access Controller

This block is a serial bus master that reads and writes 16-bit words in a byte-addressed SPI EEPROM. A command port takes a word offset, a word count and a direction. Write words arrive on a valid/ready stream, and read words leave on another valid/ready stream. Before it touches the serial pins, the block raises a bus request and waits for the grant. It then polls the device status register until the device reports ready, and only then sends the real command.

The device is byte addressed and sends the lower-addressed byte first. The controller therefore doubles the word offset to form the byte address, and swaps the two bytes of every word. On small parts with 8 address bits, the ninth address bit travels inside the opcode. A multi-word read is a single command whose words stream back to back. A multi-word write is cut into bursts that never cross an EEPROM page. Each burst repeats the status poll, the write-enable frame and the write command.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: A command is rejected when offset >= WORDS, when count is 0, or when offset+count > WORDS. A rejected command sets `err`, never raises `bus_req` and never lowers `spi_cs_n`. A command with offset+count == WORDS is accepted.
- R2: Before every command, and before every write page, the controller sends status opcode 0x05 and clocks in 8 status bits. It repeats this frame until status bit 0 (the last bit received) reads 0. No other opcode is sent while the device reports busy.
- R3: After MAX_POLL consecutive busy status reads, the controller sets `err`, returns `spi_cs_n` high, drops `bus_req` and sends no read or write opcode.
- R4: `bus_req` rises when a valid command is accepted. `spi_cs_n` stays high until `bus_gnt` is seen. `bus_req` falls once the command ends.
- R5: The address field is the word offset times two, sent in ADDR_BITS bits. Read uses opcode 0x03 and write uses 0x02. With 8 address bits, an offset of 128 or more (byte address bit 8 set) also sets opcode bit 3 (value 0x08).
- R6: The first serial byte of a word is the low byte of the port word, in both directions.
- R7: A multi-word read uses one read opcode and one address, and the words follow with no further command.
- R8: Every write burst starts with a frame carrying only opcode 0x06. A chip-select high/low standby follows, then the write opcode and the start address.
- R9: A write burst ends after a word whose following byte address is a multiple of PAGE_BYTES. The remaining words start a new poll, write-enable and write sequence.
- R10: Bits go out MSB first. `spi_mosi` changes only while `spi_sck` is low, and `spi_miso` is sampled in the last system clock of the high phase. Each half period lasts HALF clocks. `spi_sck` is low whenever `spi_cs_n` is high, including after reset.
- R11: `err` stays set until reset.
- R12: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle, command taken this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_offset | input | OFF_W | First word offset |
| cmd_count | input | OFF_W | Number of words |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Write word taken this cycle |
| wr_data | input | 16 | Write word |
| rd_valid | output | 1 | Read word present |
| rd_ready | input | 1 | Read word consumed this cycle |
| rd_data | output | 16 | Read word |
| bus_req | output | 1 | Serial bus access request |
| bus_gnt | input | 1 | Serial bus access grant |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| err | output | 1 | Sticky error: bounds violation or status timeout |

## Verification
The bench runs a behavioural EEPROM with a byte array, a write-enable latch and a busy countdown. It flags any write that lacks a preceding write-enable, that crosses a page, or that arrives while the device is busy.

- Reads starting just below and above word 128 check the address-bit-8 opcode flag. A dropped flag would return bytes from the wrong half of the array.
- Writes that straddle a page boundary must produce exactly one commit and one write-enable per page. A controller that did not split bursts would wrap inside the device page and corrupt earlier words.
- A status register held busy must give exactly MAX_POLL status frames and then an error. A missing retry limit hangs, and an off-by-one shows up in the frame count.
- Random back-pressure on the read stream catches data that changes before it is consumed.

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl #(
  parameter int WORDS      = 256,
  parameter int ADDR_BITS  = 8,
  parameter int OP_BITS    = 8,
  parameter int PAGE_BYTES = 8,
  parameter int HALF       = 2,
  parameter int MAX_POLL   = 8,
  parameter int OFF_W      = 16,
  parameter int OP_RD      = 'h03,
  parameter int OP_WR      = 'h02,
  parameter int OP_WREN    = 'h06,
  parameter int OP_RDSR    = 'h05,
  parameter int OP_A8      = 'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [OFF_W-1:0] cmd_offset,
  input  logic [OFF_W-1:0] cmd_count,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [15:0]      wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [15:0]      rd_data,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             err
);
  localparam int PH_W = $clog2(2*HALF);
  localparam int PC_W = $clog2(MAX_POLL) + 1;
  localparam logic [15:0] LD_RDSR = 16'(OP_RDSR) << (16 - OP_BITS);
  localparam logic [15:0] LD_WREN = 16'(OP_WREN) << (16 - OP_BITS);
  localparam logic [OFF_W-1:0] PG_MASK = OFF_W'(PAGE_BYTES/2 - 1);

  typedef enum logic [3:0] {
    IDLE, GRANT, SEL, POLL_OP, POLL_IN, STBY_HI, STBY_LO, WREN,
    CMD_OP, CMD_ADDR, RD_WORD, RD_HOLD, WR_FETCH, WR_WORD, FINISH
  } st_t;

  st_t st, after;
  logic [PH_W-1:0]  ph;
  logic [4:0]       nbits;
  logic [15:0]      sh, rd_buf, word_in, cmd_ld, addr_ld;
  logic [OFF_W-1:0] off, rem;
  logic [PC_W-1:0]  pc;
  logic is_wr, req, err_q, shifting, bit_end, last, tmo, a8, bad, page_edge;

  assign shifting  = st inside {POLL_OP, POLL_IN, WREN, CMD_OP, CMD_ADDR, RD_WORD, WR_WORD};
  assign bit_end   = shifting && ph == PH_W'(2*HALF - 1);
  assign last      = bit_end && nbits == 5'd1;
  assign tmo       = (st inside {SEL, STBY_HI, STBY_LO}) && ph == PH_W'(HALF - 1);
  assign word_in   = {sh[14:0], spi_miso};
  assign a8        = (ADDR_BITS == 8) && off[7];
  assign cmd_ld    = (16'(is_wr ? OP_WR : OP_RD) | (a8 ? 16'(OP_A8) : 16'd0)) << (16 - OP_BITS);
  assign addr_ld   = 16'({off, 1'b0}) << (16 - ADDR_BITS);
  assign page_edge = ((off + 1'b1) & PG_MASK) == '0;
  assign bad       = (32'(cmd_offset) >= WORDS) || (cmd_count == '0) ||
                     (32'(cmd_offset) + 32'(cmd_count) > WORDS);

  assign cmd_ready = st == IDLE;
  assign wr_ready  = st == WR_FETCH;
  assign rd_valid  = st == RD_HOLD;
  assign rd_data   = rd_buf;
  assign bus_req   = req;
  assign err       = err_q;
  assign spi_cs_n  = st inside {IDLE, GRANT, STBY_HI, FINISH};
  assign spi_sck   = shifting && ph >= PH_W'(HALF);
  assign spi_mosi  = shifting && !(st inside {POLL_IN, RD_WORD}) && sh[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; after <= IDLE; ph <= '0; nbits <= '0; sh <= '0; rd_buf <= '0;
      off <= '0; rem <= '0; pc <= '0; is_wr <= 1'b0; req <= 1'b0; err_q <= 1'b0;
    end else begin
      if (shifting)                              ph <= bit_end ? '0 : ph + 1'b1;
      else if (tmo)                              ph <= '0;
      else if (st inside {SEL, STBY_HI, STBY_LO}) ph <= ph + 1'b1;
      else                                       ph <= '0;
      if (bit_end) begin
        sh <= word_in;
        nbits <= nbits - 5'd1;
      end
      case (st)
        IDLE: if (cmd_valid) begin
          if (bad) err_q <= 1'b1;
          else begin
            req <= 1'b1; off <= cmd_offset; rem <= cmd_count; is_wr <= cmd_write; st <= GRANT;
          end
        end
        GRANT: if (bus_gnt) begin st <= SEL; pc <= '0; end
        SEL: if (tmo) begin sh <= LD_RDSR; nbits <= 5'(OP_BITS); st <= POLL_OP; end
        POLL_OP: if (last) begin nbits <= 5'd8; st <= POLL_IN; end
        POLL_IN: if (last) begin
          st <= STBY_HI;
          if (!spi_miso) after <= is_wr ? WREN : CMD_OP;
          else if (pc == PC_W'(MAX_POLL - 1)) begin err_q <= 1'b1; st <= FINISH; end
          else begin pc <= pc + 1'b1; after <= POLL_OP; end
        end
        STBY_HI: if (tmo) st <= STBY_LO;
        STBY_LO: if (tmo) begin
          st <= after;
          nbits <= 5'(OP_BITS);
          case (after)
            POLL_OP: sh <= LD_RDSR;
            WREN:    sh <= LD_WREN;
            default: sh <= cmd_ld;
          endcase
        end
        WREN: if (last) begin st <= STBY_HI; after <= CMD_OP; end
        CMD_OP: if (last) begin sh <= addr_ld; nbits <= 5'(ADDR_BITS); st <= CMD_ADDR; end
        CMD_ADDR: if (last) begin nbits <= 5'd16; st <= is_wr ? WR_FETCH : RD_WORD; end
        RD_WORD: if (last) begin rd_buf <= {word_in[7:0], word_in[15:8]}; st <= RD_HOLD; end
        RD_HOLD: if (rd_ready) begin
          rem <= rem - 1'b1;
          if (rem == OFF_W'(1)) st <= FINISH;
          else begin nbits <= 5'd16; st <= RD_WORD; end
        end
        WR_FETCH: if (wr_valid) begin
          sh <= {wr_data[7:0], wr_data[15:8]}; nbits <= 5'd16; st <= WR_WORD;
        end
        WR_WORD: if (last) begin
          off <= off + 1'b1;
          rem <= rem - 1'b1;
          if (rem == OFF_W'(1)) st <= FINISH;
          else if (page_edge) begin st <= STBY_HI; after <= POLL_OP; pc <= '0; end
          else st <= WR_FETCH;
        end
        FINISH: begin req <= 1'b0; st <= IDLE; end
        default: st <= IDLE;
      endcase
    end
  end

  p_sck_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  p_sel_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> bus_req);
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  p_reject_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_count == '0 |=> err && !bus_req);
  p_wr_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !spi_cs_n && bus_req);
endmodule

// File: tb/tb_spi_eeprom_ctrl.sv
module tb_spi_eeprom_ctrl;
  localparam int WORDS = 256, AB = 8, PB = 8, PW = PB/2, MAXP = 8, NB = 2*WORDS;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_write = 0;
  logic [15:0] cmd_offset = 0, cmd_count = 0;
  logic wr_valid = 0, rd_ready = 0, bus_gnt = 0, spi_miso = 0;
  logic [15:0] wr_data = 0;
  logic cmd_ready, wr_ready, rd_valid, bus_req, spi_cs_n, spi_sck, spi_mosi, err;
  logic [15:0] rd_data;

  always #5 clk = ~clk;

  spi_eeprom_ctrl #(.WORDS(WORDS), .ADDR_BITS(AB), .OP_BITS(8), .PAGE_BYTES(PB),
                    .HALF(2), .MAX_POLL(MAXP), .OFF_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_offset(cmd_offset), .cmd_count(cmd_count),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .err(err));

  // ---------------- behavioural EEPROM ----------------
  logic [7:0] mem [0:NB-1];
  logic [7:0] pbuf [0:31];
  logic [7:0] opc, adr, db;
  logic cs_q, sck_q, wel;
  int bitc, pn, busy;
  int n_rdsr = 0, n_busy = 0, n_wren = 0, n_commit = 0, n_read = 0, viol = 0, cs_falls = 0;
  bit stuck = 0;

  function automatic logic [7:0] base_op(input logic [7:0] o);
    return o & 8'hF7;
  endfunction

  function void dev_rise();
    if (bitc < 8) begin
      opc = {opc[6:0], spi_mosi};
      if (bitc == 7 && opc != 8'h05 && (stuck || busy > 0)) viol++;
    end else if ((base_op(opc) == 8'h03 || base_op(opc) == 8'h02) && bitc < 8 + AB) begin
      adr = {adr[6:0], spi_mosi};
    end else if (base_op(opc) == 8'h02) begin
      db = {db[6:0], spi_mosi};
      if ((bitc - 8 - AB) % 8 == 7 && pn < 32) begin pbuf[pn] = db; pn++; end
    end
    bitc++;
  endfunction

  function void dev_fall();
    int p, ba;
    if (opc == 8'h05 && bitc >= 8) begin
      p = bitc - 8;
      spi_miso = ((p % 8) == 7) ? (stuck || busy > 0) : 1'b0;
    end else if (base_op(opc) == 8'h03 && bitc >= 8 + AB) begin
      p = bitc - 8 - AB;
      ba = ({23'd0, opc[3], adr} + p / 8) % NB;
      spi_miso = mem[ba][7 - (p % 8)];
    end
  endfunction

  function void dev_end();
    int ba;
    if (opc == 8'h05 && bitc >= 16) begin
      n_rdsr++;
      if (stuck || busy > 0) n_busy++;
      if (busy > 0) busy--;
    end else if (opc == 8'h06 && bitc == 8) begin
      wel = 1; n_wren++;
    end else if (base_op(opc) == 8'h02 && bitc > 8 + AB) begin
      ba = {23'd0, opc[3], adr};
      if (!wel || pn == 0 || (bitc - 8 - AB) % 8 != 0 || (ba % PB) + pn > PB) viol++;
      else begin
        for (int i = 0; i < pn; i++) mem[(ba + i) % NB] = pbuf[i];
        n_commit++; busy = 3;
      end
      wel = 0;
    end else if (base_op(opc) == 8'h03 && bitc > 8 + AB) begin
      n_read++;
    end
  endfunction

  initial begin
    for (int b = 0; b < NB; b++) mem[b] = 8'(b * 37 + 11);
    cs_q = 1; sck_q = 0; wel = 0; busy = 0; bitc = 0; pn = 0; opc = 0; adr = 0; db = 0;
    forever begin
      @(spi_cs_n or spi_sck);
      if (spi_cs_n !== cs_q) begin
        if (!spi_cs_n) begin
          bitc = 0; opc = 0; adr = 0; pn = 0; spi_miso = 0; cs_falls++;
        end else dev_end();
        cs_q = spi_cs_n;
      end
      if (spi_sck !== sck_q) begin
        if (!spi_cs_n) begin
          if (spi_sck) dev_rise(); else dev_fall();
        end
        sck_q = spi_sck;
      end
    end
  end

  // ---------------- streams, grant and per-clock reference checks ----------------
  logic [15:0] wq [0:255];
  logic [15:0] rq [0:1023];
  int wtot = 0, widx = 0, rtot = 0, gcnt = 0, ncyc = 0, req_rises = 0;
  int mon_checks = 0, mon_fails = 0;
  bit acc = 0, err_q = 0, req_q = 0, rv_q = 0, rr_q = 0;
  logic [15:0] rd_q = 0;

  always @(negedge clk) begin
    ncyc++;
    if (bus_req) begin gcnt++; bus_gnt = gcnt > 5; end
    else begin gcnt = 0; bus_gnt = 0; end
    rd_ready = (ncyc % 3) != 0;
    if (rd_valid && rd_ready && rtot < 1024) begin rq[rtot] = rd_data; rtot++; end
    if (acc) begin widx++; acc = 0; end
    wr_valid = widx < wtot;
    wr_data = wq[widx % 256];
    acc = wr_valid && wr_ready;
    if (bus_req && !req_q) req_rises++;
    if (rst_n) begin
      mon_checks += 4;
      if (spi_cs_n && spi_sck) begin
        mon_fails++; $display("FAIL R10 sck=%0b expected 0 while cs_n high", spi_sck);
      end
      if (!spi_cs_n && !bus_gnt) begin
        mon_fails++; $display("FAIL R4 cs_n=%0b expected 1 before grant", spi_cs_n);
      end
      if (err_q && !err) begin
        mon_fails++; $display("FAIL R11 err=%0b expected 1", err);
      end
      if (rv_q && !rr_q && (!rd_valid || rd_data !== rd_q)) begin
        mon_fails++; $display("FAIL R12 rd_valid=%0b rd_data=%h expected 1 %h", rd_valid, rd_data, rd_q);
      end
      err_q = err;
    end else err_q = 0;
    req_q = bus_req; rv_q = rd_valid; rr_q = rd_ready; rd_q = rd_data;
  end

  // ---------------- main sequence ----------------
  int checks = 0, fails = 0;
  logic [15:0] exp_w [0:WORDS-1];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", what, act, exp); end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic issue(input bit w, input int off, input int cnt);
    int g;
    @(negedge clk);
    cmd_write = w; cmd_offset = 16'(off); cmd_count = 16'(cnt); cmd_valid = 1;
    @(posedge clk);
    @(negedge clk); cmd_valid = 0;
    g = 0;
    while (!(cmd_ready && !bus_req) && g < 40000) begin @(negedge clk); g++; end
  endtask

  task automatic do_read(input int off, input int cnt, input string tag);
    int r0, nr0, v0;
    r0 = rtot; nr0 = n_read; v0 = viol;
    issue(0, off, cnt);
    repeat (2) @(negedge clk);
    chk(rtot - r0 == cnt, {tag, " R7 word count"}, rtot - r0, cnt);
    chk(n_read - nr0 == 1, {tag, " R7 R10 single read command"}, n_read - nr0, 1);
    chk(viol == v0, {tag, " R2 device protocol"}, viol, v0);
    for (int i = 0; i < cnt && r0 + i < rtot; i++)
      chk(rq[r0 + i] == exp_w[off + i], {tag, " R5 R6 read data"}, rq[r0 + i], exp_w[off + i]);
  endtask

  task automatic do_write(input int off, input int cnt);
    int c0, e0, v0, pages;
    c0 = n_commit; e0 = n_wren; v0 = viol;
    pages = (off + cnt - 1) / PW - off / PW + 1;
    for (int i = 0; i < cnt; i++) begin
      wq[(wtot + i) % 256] = 16'((off + i) * 16'h0101) ^ 16'h5A3C;
      exp_w[off + i] = 16'((off + i) * 16'h0101) ^ 16'h5A3C;
    end
    wtot += cnt;
    issue(1, off, cnt);
    chk(n_commit - c0 == pages, "R9 page bursts", n_commit - c0, pages);
    chk(n_wren - e0 == pages, "R8 write-enable per burst", n_wren - e0, pages);
    chk(viol == v0, "R8 R9 write protocol", viol, v0);
    do_read(off, cnt, "writeback R6");
  endtask

  task automatic reject(input int off, input int cnt);
    int f0, q0;
    do_reset();
    chk(err == 0, "R11 err clear after reset", err, 0);
    f0 = cs_falls; q0 = req_rises;
    issue(0, off, cnt);
    chk(err == 1, "R1 err on bad command", err, 1);
    chk(cs_falls == f0, "R1 no chip select", cs_falls - f0, 0);
    chk(req_rises == q0, "R1 no bus request", req_rises - q0, 0);
  endtask

  task automatic run_all();
    int s0, r0;
    for (int k = 0; k < WORDS; k++) exp_w[k] = {8'(((2*k+1) * 37) + 11), 8'((2*k * 37) + 11)};
    do_reset();
    chk(spi_cs_n == 1, "R10 reset cs_n", spi_cs_n, 1);
    chk(spi_sck == 0, "R10 reset sck", spi_sck, 0);
    chk(bus_req == 0, "R4 reset req", bus_req, 0);
    chk(err == 0, "R11 reset err", err, 0);
    chk(cmd_ready == 1, "R4 reset ready", cmd_ready, 1);

    do_read(5, 1, "single");
    do_read(20, 4, "burst");
    do_read(126, 4, "cross128");
    do_read(130, 3, "R5 high half");
    do_write(10, 3);
    chk(n_busy >= 3, "R2 busy status polled", n_busy, 3);
    do_write(200, 5);
    do_write(7, 1);
    do_write(252, 4);
    do_read(250, 6, "R1 to end");

    reject(256, 1);
    reject(5, 0);
    reject(250, 7);

    do_reset();
    stuck = 1;
    s0 = n_rdsr; r0 = n_read;
    issue(0, 0, 2);
    chk(err == 1, "R3 timeout err", err, 1);
    chk(n_rdsr - s0 == MAXP, "R3 status frame count", n_rdsr - s0, MAXP);
    chk(n_read == r0, "R3 no read sent", n_read - r0, 0);
    chk(spi_cs_n == 1 && bus_req == 0, "R3 released", {spi_cs_n, bus_req}, 2);
    repeat (20) @(negedge clk);
    chk(err == 1, "R11 err held", err, 1);
    stuck = 0;
    do_reset();
    do_read(0, 2, "after timeout");
    chk(err == 0, "R11 err after clean run", err, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hang expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
    $finish;
  end
endmodule